// File: doc/BRIEF.md
# Banked Internal RAM Address Decoder

This block sits between a CPU's operand fetch logic and its 256-byte on-chip data RAM. It takes one access request per cycle and turns it into a RAM byte address or a special-function-register select. Three kinds of request are handled: a plain byte access, a register operand access and a single-bit access.

A byte access carries an 8-bit address and a flag that says whether the address came from indirect addressing. The lower half of the address space always reaches RAM. The upper half reaches RAM only when the access is indirect; a direct access to the upper half selects the SFR space instead. A register operand access carries a 3-bit register number. It is moved into one of four 8-byte banks at the bottom of RAM, and the bank is chosen by two bits of the status word. A bit access carries a bit address. Bit addresses below 80H fall in a 16-byte bit-addressable window that starts at byte 20H. Higher bit addresses are passed to the SFR side and flagged as SFR bit accesses.

All decoded outputs are registered and appear one cycle after the request. For RAM bit accesses the block also extracts the addressed bit from the RAM read data and builds the write-back byte for a read-modify-write.

Top module: `iram_decode`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ram_sel, sfr_sel and sfr_bit are 0, and ram_addr, sfr_addr and bit_pos are 0.
- R2: A byte access (acc_kind = 0) to an address in 00H–7FH gives ram_sel = 1 and ram_addr = the address in the following cycle, with sfr_sel = 0, whatever the value of acc_indirect.
- R3: A byte access to an address in 80H–FFH with acc_indirect = 1 gives ram_sel = 1, ram_addr = the address and sfr_sel = 0 in the following cycle.
- R4: A byte access to an address in 80H–FFH with acc_indirect = 0 gives sfr_sel = 1, sfr_addr = the address, sfr_bit = 0 and ram_sel = 0 in the following cycle.
- R5: A register access (acc_kind = 1) with register number n gives ram_sel = 1 and ram_addr = {3'b000, psw[4:3], n} in the following cycle. acc_indirect, acc_addr and the other psw bits have no effect on it.
- R6: A bit access (acc_kind = 2) with bit address b below 80H gives ram_sel = 1, ram_addr = 20H + b[6:3] and bit_pos = b[2:0] in the following cycle, with sfr_sel = 0.
- R7: A bit access with b at 80H or above gives sfr_sel = 1, sfr_bit = 1, sfr_addr = b and bit_pos = b[2:0] in the following cycle, with ram_sel = 0.
- R8: In the cycle after a bit access, bit_rd equals ram_rdata[bit_pos], and bit_wbyte equals ram_rdata with only bit bit_pos replaced by the bit_wdata value given with the request.
- R9: When acc_valid = 0, or when acc_kind = 3, all selects, addresses and bit_pos are 0 in the following cycle. ram_sel and sfr_sel are never 1 together.
- R10: bit_pos is 0 in the cycle after any access that is not a bit access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 byte, 1 register operand, 2 bit, 3 none |
| acc_indirect | input | 1 | Byte access came from indirect addressing |
| acc_addr | input | 8 | Byte address or bit address |
| acc_reg | input | 3 | Register number for a register access |
| psw | input | 8 | Status word; bits 4:3 choose the register bank |
| bit_wdata | input | 1 | New bit value for a bit write |
| ram_rdata | input | 8 | RAM read data of the decoded byte |
| ram_sel | output | 1 | Access goes to RAM |
| ram_addr | output | 8 | RAM byte address |
| sfr_sel | output | 1 | Access goes to the SFR space |
| sfr_addr | output | 8 | SFR byte address, or bit address for an SFR bit access |
| sfr_bit | output | 1 | The SFR access is a bit access |
| bit_pos | output | 3 | Bit position within the byte |
| bit_rd | output | 1 | Addressed bit extracted from ram_rdata |
| bit_wbyte | output | 8 | ram_rdata with the addressed bit replaced |

## Verification
Random byte accesses cover both halves of the address space under both addressing flags, so a decoder that routes the upper half by address alone, or by mode alone, fails. Register accesses use random status words and random values on the unused inputs, which separates a bank taken from psw[4:3] from one taken from neighbouring bits or from acc_addr. Bit accesses cover both sides of 80H with random read data, and the corners 00H, 7FH, 80H and FFH are driven directly, which exposes an off-by-one in the 20H window and a merge that disturbs bits other than the addressed one. Idle and kind-3 cycles are mixed in to show that outputs clear.

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_REG  = 2'd1,
        ACC_BIT  = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/iram_bank_map.sv
module iram_bank_map #(
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  reg_num,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam int PAD_W = ADDR_W - BANK_W - REG_W;

    // Register file occupies the bottom of RAM: bank picks the 2^REG_W slice.
    assign byte_addr = {{PAD_W{1'b0}}, bank, reg_num};

endmodule

// File: rtl/iram_bit_map.sv
module iram_bit_map #(
    parameter int              ADDR_W = 8,
    parameter int              POS_W  = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'h20
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              is_sfr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [POS_W-1:0]  pos
);
    localparam int IDX_W = ADDR_W - 1 - POS_W;

    logic [IDX_W-1:0] byte_idx;

    assign is_sfr    = bit_addr[ADDR_W-1];
    assign byte_idx  = bit_addr[ADDR_W-2:POS_W];
    assign byte_addr = BASE + ADDR_W'(byte_idx);
    assign pos       = bit_addr[POS_W-1:0];

endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
    parameter int DATA_W = 8,
    parameter int POS_W  = 3
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [POS_W-1:0]  pos,
    input  logic              wbit,
    output logic              rbit,
    output logic [DATA_W-1:0] wbyte
);
    assign rbit = rdata[pos];

    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign wbyte[g] = (pos == POS_W'(g)) ? wbit : rdata[g];
    end

endmodule

// File: rtl/iram_decode.sv
module iram_decode
    import iram_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                REG_W    = 3,
    parameter int                BANK_W   = 2,
    parameter int                BANK_LSB = 3,
    parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_indirect,
    input  logic [7:0]        acc_addr,
    input  logic [2:0]        acc_reg,
    input  logic [7:0]        psw,
    input  logic              bit_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              ram_sel,
    output logic [7:0]        ram_addr,
    output logic              sfr_sel,
    output logic [7:0]        sfr_addr,
    output logic              sfr_bit,
    output logic [2:0]        bit_pos,
    output logic              bit_rd,
    output logic [7:0]        bit_wbyte
);
    localparam int POS_W = $clog2(DATA_W);

    typedef struct packed {
        logic              ram_sel;
        logic [ADDR_W-1:0] ram_addr;
        logic              sfr_sel;
        logic [ADDR_W-1:0] sfr_addr;
        logic              sfr_bit;
        logic [POS_W-1:0]  bit_pos;
        logic              wbit;
    } dec_t;

    dec_t st_d, st_q;

    acc_kind_e         kind;
    logic [ADDR_W-1:0] reg_byte;
    logic              bit_is_sfr;
    logic [ADDR_W-1:0] bit_byte;
    logic [POS_W-1:0]  bit_ofs;

    assign kind = acc_kind_e'(acc_kind);

    iram_bank_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .REG_W  (REG_W)
    ) u_bank (
        .bank      (psw[BANK_LSB +: BANK_W]),
        .reg_num   (acc_reg),
        .byte_addr (reg_byte)
    );

    iram_bit_map #(
        .ADDR_W (ADDR_W),
        .POS_W  (POS_W),
        .BASE   (BIT_BASE)
    ) u_bitmap (
        .bit_addr  (acc_addr),
        .is_sfr    (bit_is_sfr),
        .byte_addr (bit_byte),
        .pos       (bit_ofs)
    );

    always_comb begin
        st_d = '0;
        if (acc_valid) begin
            unique case (kind)
                ACC_BYTE: begin
                    // Upper half is shared: indirect reaches RAM, direct reaches SFRs.
                    if (acc_addr[ADDR_W-1] && !acc_indirect) begin
                        st_d.sfr_sel  = 1'b1;
                        st_d.sfr_addr = acc_addr;
                    end else begin
                        st_d.ram_sel  = 1'b1;
                        st_d.ram_addr = acc_addr;
                    end
                end
                ACC_REG: begin
                    st_d.ram_sel  = 1'b1;
                    st_d.ram_addr = reg_byte;
                end
                ACC_BIT: begin
                    st_d.bit_pos = bit_ofs;
                    st_d.wbit    = bit_wdata;
                    if (bit_is_sfr) begin
                        st_d.sfr_sel  = 1'b1;
                        st_d.sfr_bit  = 1'b1;
                        st_d.sfr_addr = acc_addr;
                    end else begin
                        st_d.ram_sel  = 1'b1;
                        st_d.ram_addr = bit_byte;
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    iram_bit_merge #(
        .DATA_W (DATA_W),
        .POS_W  (POS_W)
    ) u_merge (
        .rdata (ram_rdata),
        .pos   (st_q.bit_pos),
        .wbit  (st_q.wbit),
        .rbit  (bit_rd),
        .wbyte (bit_wbyte)
    );

    assign ram_sel  = st_q.ram_sel;
    assign ram_addr = st_q.ram_addr;
    assign sfr_sel  = st_q.sfr_sel;
    assign sfr_addr = st_q.sfr_addr;
    assign sfr_bit  = st_q.sfr_bit;
    assign bit_pos  = st_q.bit_pos;

    // ---------------- assertions ----------------
    p_excl_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, sfr_sel}));

    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!ram_sel && !sfr_sel && !sfr_bit && bit_pos == '0));

    p_low_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0 && !acc_addr[7])
        |=> (ram_sel && ram_addr == $past(acc_addr)));

    p_upper_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0 && acc_addr[7] && !acc_indirect)
        |=> (sfr_sel && !ram_sel && sfr_addr == $past(acc_addr)));

    p_upper_indirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0 && acc_addr[7] && acc_indirect)
        |=> (ram_sel && ram_addr == $past(acc_addr)));

    p_reg_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd1)
        |=> (ram_sel && ram_addr[7:5] == 3'b000
             && ram_addr[4:3] == $past(psw[4:3]) && ram_addr[2:0] == $past(acc_reg)));

    p_bit_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd2 && !acc_addr[7])
        |=> (ram_sel && ram_addr >= 8'h20 && ram_addr <= 8'h2F));

    p_sfr_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd2 && acc_addr[7])
        |=> (sfr_sel && sfr_bit && !ram_sel));

    p_merge_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bit_wbyte ^ ram_rdata) <= 1);

endmodule

// File: tb/sim_iram_decode.sv
module sim_iram_decode;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [1:0] acc_kind;
    logic       acc_indirect;
    logic [7:0] acc_addr;
    logic [2:0] acc_reg;
    logic [7:0] psw;
    logic       bit_wdata;
    logic [7:0] ram_rdata;
    logic       ram_sel;
    logic [7:0] ram_addr;
    logic       sfr_sel;
    logic [7:0] sfr_addr;
    logic       sfr_bit;
    logic [2:0] bit_pos;
    logic       bit_rd;
    logic [7:0] bit_wbyte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    iram_decode u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_indirect(acc_indirect), .acc_addr(acc_addr), .acc_reg(acc_reg),
        .psw(psw), .bit_wdata(bit_wdata), .ram_rdata(ram_rdata),
        .ram_sel(ram_sel), .ram_addr(ram_addr), .sfr_sel(sfr_sel),
        .sfr_addr(sfr_addr), .sfr_bit(sfr_bit), .bit_pos(bit_pos),
        .bit_rd(bit_rd), .bit_wbyte(bit_wbyte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected-value model built from the requirements.
    typedef struct {
        logic       rs;
        logic [7:0] ra;
        logic       ss;
        logic [7:0] sa;
        logic       sb;
        logic [2:0] bp;
        string      req;
    } exp_t;

    function automatic exp_t model(input logic v, input logic [1:0] k, input logic ind,
                                   input logic [7:0] a, input logic [2:0] r, input logic [7:0] p);
        exp_t e;
        e.rs = 0; e.ra = 0; e.ss = 0; e.sa = 0; e.sb = 0; e.bp = 0; e.req = "R9";
        if (v && k == 2'd0) begin
            if (a < 8'h80)     begin e.rs = 1; e.ra = a; e.req = "R2"; end
            else if (ind)      begin e.rs = 1; e.ra = a; e.req = "R3"; end
            else               begin e.ss = 1; e.sa = a; e.req = "R4"; end
        end else if (v && k == 2'd1) begin
            e.rs = 1; e.ra = {3'b000, p[4:3], r}; e.req = "R5";
        end else if (v && k == 2'd2) begin
            e.bp = a[2:0];
            if (a < 8'h80) begin e.rs = 1; e.ra = 8'h20 + {4'h0, a[6:3]}; e.req = "R6"; end
            else           begin e.ss = 1; e.sb = 1; e.sa = a; e.req = "R7"; end
        end
        return e;
    endfunction

    task automatic access(input logic v, input logic [1:0] k, input logic ind,
                          input logic [7:0] a, input logic [2:0] r, input logic [7:0] p,
                          input logic wb, input logic [7:0] rd);
        exp_t e;
        logic [7:0] mb;
        @(negedge clk);
        acc_valid = v; acc_kind = k; acc_indirect = ind; acc_addr = a;
        acc_reg = r; psw = p; bit_wdata = wb; ram_rdata = rd;
        e = model(v, k, ind, a, r, p);
        @(posedge clk);
        #2;
        chk(e.req, {7'b0, ram_sel}, {7'b0, e.rs});
        chk(e.req, ram_sel ? ram_addr : 8'h00, e.ra);
        chk(e.req, {7'b0, sfr_sel}, {7'b0, e.ss});
        chk(e.req, sfr_sel ? sfr_addr : 8'h00, e.sa);
        chk(e.req, {7'b0, sfr_bit}, {7'b0, e.sb});
        if (v && k == 2'd2) begin
            chk(e.req, {5'b0, bit_pos}, {5'b0, e.bp});
            mb = rd;
            mb[a[2:0]] = wb;
            chk("R8", {7'b0, bit_rd}, {7'b0, rd[a[2:0]]});
            chk("R8", bit_wbyte, mb);
        end else begin
            chk("R10", {5'b0, bit_pos}, 8'h00);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; acc_valid = 0; acc_kind = 0; acc_indirect = 0; acc_addr = 0;
        acc_reg = 0; psw = 0; bit_wdata = 0; ram_rdata = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", {7'b0, ram_sel}, 8'h00);
        chk("R1", {7'b0, sfr_sel}, 8'h00);
        chk("R1", {7'b0, sfr_bit}, 8'h00);
        chk("R1", ram_addr, 8'h00);
        chk("R1", sfr_addr, 8'h00);
        chk("R1", {5'b0, bit_pos}, 8'h00);
        @(negedge clk);
        rst_n = 1;

        // Directed corners
        access(1, 2'd0, 0, 8'h7F, 0, 0, 0, 8'h00);        // R2 top of low half, direct
        access(1, 2'd0, 1, 8'h00, 0, 0, 0, 8'h00);        // R2 indirect
        access(1, 2'd0, 1, 8'h80, 0, 0, 0, 8'h00);        // R3
        access(1, 2'd0, 0, 8'h80, 0, 0, 0, 8'h00);        // R4
        access(1, 2'd0, 0, 8'hFF, 0, 0, 0, 8'h00);        // R4
        access(1, 2'd1, 1, 8'hFF, 3'd7, 8'hE7, 0, 8'h00); // R5 bank 0, noisy psw
        access(1, 2'd1, 0, 8'h55, 3'd0, 8'h18, 0, 8'h00); // R5 bank 3
        access(1, 2'd2, 0, 8'h00, 0, 0, 1, 8'h00);        // R6 first bit
        access(1, 2'd2, 0, 8'h7F, 0, 0, 0, 8'hFF);        // R6 last bit
        access(1, 2'd2, 0, 8'h80, 0, 0, 1, 8'h5A);        // R7
        access(1, 2'd2, 0, 8'hFF, 0, 0, 0, 8'hA5);        // R7
        access(0, 2'd0, 0, 8'h10, 0, 0, 0, 8'h00);        // R9 idle
        access(1, 2'd3, 1, 8'h90, 3'd2, 8'h18, 1, 8'h00); // R9 kind 3

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic v;
            v = ($urandom % 8) != 0;
            access(v, 2'($urandom), 1'($urandom), 8'($urandom), 3'($urandom),
                   8'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule